// File: doc/BRIEF.md
# Configuration Image Checksum Sequencer

This block manages a 64-word, 16-bit configuration image held in a serial EEPROM. It sits above a serial EEPROM master and drives it through a single-command start/done handshake: one command is issued, and the next is issued only after the master reports completion. The master covers each write's self-timed programming wait before it reports done.

A verify request reads the whole image in ascending address order into a local buffer and adds the words into a 16-bit running sum. The image is reported valid only when that sum equals a fixed constant and a two-bit signature field in word 10 carries the expected code. A program request first enables writes in the EEPROM, then writes words 0 to 62 from the local buffer. It closes with word 63, a seal word chosen so that the 64-word sum reaches the constant. Software fills the buffer through a host port while the block is idle. An optional read-back pass after programming re-checks the stored image.

Top module: `eeimg_seq`

## Requirements
- R1: After reset, busy, done, valid, sum_ok, sig_ok and cmd_start are all low.
- R2: A verify pass issues 64 read commands (cmd_op 2'b00) to addresses 0,1,...,63 in that order, and never issues a command while an earlier one is still awaiting cmd_done.
- R3: At the end of a verify pass, sum_ok is high exactly when the sum modulo 2^16 of the 64 words read equals 16'hBABA.
- R4: At the end of a verify pass, sig_ok is high exactly when bits 15:14 of word 10 equal 2'b01, and valid equals sum_ok AND sig_ok. All three update in the single cycle where done pulses high, and busy is low in that cycle.
- R5: Each word read during a verify pass is stored in the local buffer at its address and can be read on the host read port afterwards.
- R6: A host buffer write takes effect when busy is low and is ignored while busy is high.
- R7: A program pass issues a write-enable command (cmd_op 2'b10, cmd_addr 0) first. It then issues write commands (cmd_op 2'b01) to addresses 0 to 62 in ascending order, each carrying the buffer word of that address.
- R8: The last write of a program pass goes to address 63 with data 16'hBABA minus the sum modulo 2^16 of buffer words 0 to 62.
- R9: While busy is high, prog_req and verify_req are ignored, and no command is issued because of them. When both requests arrive together in idle, verify is taken.
- R10: With rbk_en high when a program request is accepted, a full verify pass follows the seal write, and the flags report that pass. With rbk_en low, done pulses after the seal write and no further command follows.
- R11: busy rises in the cycle after a request is accepted and stays high until the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| verify_req | input | 1 | Start a verify pass (sampled when idle) |
| prog_req | input | 1 | Start a program pass (sampled when idle) |
| rbk_en | input | 1 | Run a read-back verify after programming, sampled with prog_req |
| hst_we | input | 1 | Host buffer write strobe |
| hst_addr | input | 6 | Host buffer write address |
| hst_wdata | input | 16 | Host buffer write data |
| hst_raddr | input | 6 | Host buffer read address |
| hst_rdata | output | 16 | Host buffer read data (combinational) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| valid | output | 1 | Last verify found the image valid |
| sum_ok | output | 1 | Last verify found the sum correct |
| sig_ok | output | 1 | Last verify found the signature correct |
| cmd_start | output | 1 | One-cycle command strobe to the EEPROM master |
| cmd_op | output | 2 | Command: 00 read, 01 write, 10 write enable |
| cmd_addr | output | 6 | Command word address |
| cmd_wdata | output | 16 | Write data for a write command |
| cmd_done | input | 1 | One-cycle completion pulse from the master |
| cmd_rdata | input | 16 | Read data, valid with cmd_done |

## Verification
The assertions take for granted that the master pulses cmd_done only for a command it has accepted, never in the same cycle as cmd_start, and that a write's done arrives only after its programming wait. The bench master model keeps to these rules. It latches each strobe at the falling edge and answers at least one cycle later, after a configurable latency. Requests and host writes are driven at falling edges, so each is seen at exactly one rising edge.

// File: rtl/eeimg_pkg.sv
package eeimg_pkg;

  localparam int EE_DW = 16;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_WREN  = 2'b10
  } ee_op_t;

  // Seal word that brings the running sum of the data words up to the target.
  function automatic logic [EE_DW-1:0] f_seal(input logic [EE_DW-1:0] target,
                                              input logic [EE_DW-1:0] partial);
    return target - partial;
  endfunction

  // Modulo-2^16 accumulation step.
  function automatic logic [EE_DW-1:0] f_add(input logic [EE_DW-1:0] acc,
                                             input logic [EE_DW-1:0] word);
    return acc + word;
  endfunction

  // Signature field check on the top two bits of a word.
  function automatic logic f_sig_match(input logic [EE_DW-1:0] word,
                                       input logic [1:0] want);
    return word[EE_DW-1 -: 2] == want;
  endfunction

endpackage

// File: rtl/eeimg_buf.sv
module eeimg_buf
  import eeimg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [EE_DW-1:0] wdata,
  input  logic [AW-1:0]    ra_host,
  output logic [EE_DW-1:0] rd_host,
  input  logic [AW-1:0]    ra_seq,
  output logic [EE_DW-1:0] rd_seq
);

  localparam int DEPTH = 1 << AW;

  logic [EE_DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_host = mem[ra_host];
  assign rd_seq  = mem[ra_seq];

endmodule

// File: rtl/eeimg_acc.sv
module eeimg_acc
  import eeimg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [EE_DW-1:0] val,
  output logic [EE_DW-1:0] sum
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= f_add(sum, val);
  end

endmodule

// File: rtl/eeimg_fsm.sv
module eeimg_fsm
  import eeimg_pkg::*;
#(
  parameter int               AW       = 6,
  parameter logic [EE_DW-1:0] MAGIC    = 16'hBABA,
  parameter int               SIG_WORD = 10,
  parameter logic [1:0]       SIG_VAL  = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             verify_req,
  input  logic             prog_req,
  input  logic             rbk_en,
  // master handshake
  output logic             cmd_start,
  output logic [1:0]       cmd_op,
  output logic [AW-1:0]    cmd_addr,
  output logic [EE_DW-1:0] cmd_wdata,
  input  logic             cmd_done,
  input  logic [EE_DW-1:0] cmd_rdata,
  // buffer side
  output logic             seq_we,
  output logic [AW-1:0]    seq_waddr,
  output logic [EE_DW-1:0] seq_wdata,
  output logic [AW-1:0]    seq_raddr,
  input  logic [EE_DW-1:0] seq_rdata,
  // accumulator side
  output logic             acc_clr,
  output logic             acc_add,
  output logic [EE_DW-1:0] acc_val,
  input  logic [EE_DW-1:0] acc_sum,
  // status
  output logic             busy,
  output logic             done,
  output logic             valid,
  output logic             sum_ok,
  output logic             sig_ok
);

  localparam int            DEPTH     = 1 << AW;
  localparam logic [AW-1:0] LAST      = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_DATA = AW'(DEPTH - 2);
  localparam logic [AW-1:0] SIG_IDX   = AW'(SIG_WORD);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_RD_FIN,
    S_EN_REQ, S_EN_WAIT, S_WR_REQ, S_WR_WAIT,
    S_CK_REQ, S_CK_WAIT
  } st_t;

  st_t           st;
  logic [AW-1:0] idx;
  logic          rbk_q;
  logic          sig_q;
  logic          done_q;
  logic          sum_ok_q;
  logic          sig_ok_q;

  // named internal events
  logic          ev_accept_v;
  logic          ev_accept_p;
  logic          ev_rd_done;
  logic          ev_seal_done;
  logic [EE_DW-1:0] seal_word;

  assign ev_accept_v  = (st == S_IDLE) && verify_req;
  assign ev_accept_p  = (st == S_IDLE) && !verify_req && prog_req;
  assign ev_rd_done   = (st == S_RD_WAIT) && cmd_done;
  assign ev_seal_done = (st == S_CK_WAIT) && cmd_done;
  assign seal_word    = f_seal(MAGIC, acc_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      rbk_q    <= 1'b0;
      sig_q    <= 1'b0;
      done_q   <= 1'b0;
      sum_ok_q <= 1'b0;
      sig_ok_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (ev_accept_v) begin
            idx <= '0;
            st  <= S_RD_REQ;
          end else if (ev_accept_p) begin
            rbk_q <= rbk_en;
            st    <= S_EN_REQ;
          end
        end
        S_RD_REQ: st <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (cmd_done) begin
            if (idx == SIG_IDX) sig_q <= f_sig_match(cmd_rdata, SIG_VAL);
            if (idx == LAST) begin
              st <= S_RD_FIN;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_RD_REQ;
            end
          end
        end
        S_RD_FIN: begin
          sum_ok_q <= (acc_sum == MAGIC);
          sig_ok_q <= sig_q;
          done_q   <= 1'b1;
          st       <= S_IDLE;
        end
        S_EN_REQ: st <= S_EN_WAIT;
        S_EN_WAIT: begin
          if (cmd_done) begin
            idx <= '0;
            st  <= S_WR_REQ;
          end
        end
        S_WR_REQ: st <= S_WR_WAIT;
        S_WR_WAIT: begin
          if (cmd_done) begin
            if (idx == LAST_DATA) begin
              st <= S_CK_REQ;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_WR_REQ;
            end
          end
        end
        S_CK_REQ: st <= S_CK_WAIT;
        S_CK_WAIT: begin
          if (cmd_done) begin
            if (rbk_q) begin
              idx <= '0;
              st  <= S_RD_REQ;
            end else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // command outputs
  always_comb begin
    cmd_start = 1'b0;
    cmd_op    = OP_READ;
    cmd_addr  = idx;
    cmd_wdata = '0;
    unique case (st)
      S_RD_REQ: begin
        cmd_start = 1'b1;
        cmd_op    = OP_READ;
      end
      S_EN_REQ: begin
        cmd_start = 1'b1;
        cmd_op    = OP_WREN;
        cmd_addr  = '0;
      end
      S_WR_REQ: begin
        cmd_start = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_wdata = seq_rdata;
      end
      S_CK_REQ: begin
        cmd_start = 1'b1;
        cmd_op    = OP_WRITE;
        cmd_addr  = LAST;
        cmd_wdata = seal_word;
      end
      default: ;
    endcase
  end

  // buffer and accumulator control
  always_comb begin
    seq_we    = 1'b0;
    seq_waddr = idx;
    seq_wdata = cmd_rdata;
    if (ev_rd_done) begin
      seq_we = 1'b1;
    end else if (st == S_CK_REQ) begin
      seq_we    = 1'b1;
      seq_waddr = LAST;
      seq_wdata = seal_word;
    end
  end

  assign seq_raddr = idx;
  assign acc_clr   = ev_accept_v || ev_accept_p || (ev_seal_done && rbk_q);
  assign acc_add   = ev_rd_done || (st == S_WR_REQ);
  assign acc_val   = (st == S_WR_REQ) ? seq_rdata : cmd_rdata;

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign sum_ok = sum_ok_q;
  assign sig_ok = sig_ok_q;
  assign valid  = sum_ok_q && sig_ok_q;

  // ---------------------------------------------------------------
  // assertion trackers
  logic          pend_q;
  logic          wren_q;
  logic [AW:0]   nwr_q;
  logic [AW-1:0] last_wa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      wren_q    <= 1'b0;
      nwr_q     <= '0;
      last_wa_q <= '0;
    end else begin
      if (cmd_start)     pend_q <= 1'b1;
      else if (cmd_done) pend_q <= 1'b0;
      if (st == S_IDLE) begin
        wren_q <= 1'b0;
        nwr_q  <= '0;
      end else if (cmd_start && cmd_op == OP_WREN) begin
        wren_q <= 1'b1;
      end else if (cmd_start && cmd_op == OP_WRITE) begin
        nwr_q     <= nwr_q + 1'b1;
        last_wa_q <= cmd_addr;
      end
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !pend_q); // R2
  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == OP_WRITE) |-> wren_q); // R7
  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == OP_WRITE && nwr_q != '0) |-> (cmd_addr == last_wa_q + 1'b1)); // R7
  AST_SEAL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == OP_WRITE && cmd_addr == LAST) |-> (nwr_q == (AW+1)'(DEPTH - 1))); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

endmodule

// File: rtl/eeimg_seq.sv
module eeimg_seq
  import eeimg_pkg::*;
#(
  parameter int               AW       = 6,
  parameter logic [15:0]      MAGIC    = 16'hBABA,
  parameter int               SIG_WORD = 10,
  parameter logic [1:0]       SIG_VAL  = 2'b01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          verify_req,
  input  logic          prog_req,
  input  logic          rbk_en,
  input  logic          hst_we,
  input  logic [AW-1:0] hst_addr,
  input  logic [15:0]   hst_wdata,
  input  logic [AW-1:0] hst_raddr,
  output logic [15:0]   hst_rdata,
  output logic          busy,
  output logic          done,
  output logic          valid,
  output logic          sum_ok,
  output logic          sig_ok,
  output logic          cmd_start,
  output logic [1:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [15:0]   cmd_wdata,
  input  logic          cmd_done,
  input  logic [15:0]   cmd_rdata
);

  logic             seq_we;
  logic [AW-1:0]    seq_waddr;
  logic [EE_DW-1:0] seq_wdata;
  logic [AW-1:0]    seq_raddr;
  logic [EE_DW-1:0] seq_rdata;
  logic             acc_clr;
  logic             acc_add;
  logic [EE_DW-1:0] acc_val;
  logic [EE_DW-1:0] acc_sum;

  logic             buf_we;
  logic [AW-1:0]    buf_waddr;
  logic [EE_DW-1:0] buf_wdata;
  logic             host_wr_ok;

  // the sequencer owns the buffer write port while a pass runs
  assign host_wr_ok = hst_we && !busy;
  assign buf_we     = seq_we || host_wr_ok;
  assign buf_waddr  = seq_we ? seq_waddr : hst_addr;
  assign buf_wdata  = seq_we ? seq_wdata : hst_wdata;

  eeimg_buf #(.AW(AW)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .ra_host (hst_raddr),
    .rd_host (hst_rdata),
    .ra_seq  (seq_raddr),
    .rd_seq  (seq_rdata)
  );

  eeimg_acc u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .add   (acc_add),
    .val   (acc_val),
    .sum   (acc_sum)
  );

  eeimg_fsm #(
    .AW       (AW),
    .MAGIC    (MAGIC),
    .SIG_WORD (SIG_WORD),
    .SIG_VAL  (SIG_VAL)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .verify_req (verify_req),
    .prog_req   (prog_req),
    .rbk_en     (rbk_en),
    .cmd_start  (cmd_start),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_wdata  (cmd_wdata),
    .cmd_done   (cmd_done),
    .cmd_rdata  (cmd_rdata),
    .seq_we     (seq_we),
    .seq_waddr  (seq_waddr),
    .seq_wdata  (seq_wdata),
    .seq_raddr  (seq_raddr),
    .seq_rdata  (seq_rdata),
    .acc_clr    (acc_clr),
    .acc_add    (acc_add),
    .acc_val    (acc_val),
    .acc_sum    (acc_sum),
    .busy       (busy),
    .done       (done),
    .valid      (valid),
    .sum_ok     (sum_ok),
    .sig_ok     (sig_ok)
  );

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_we) |-> !buf_we); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy); // R11

endmodule

// File: tb/tb_eeimg_seq.sv
module tb_eeimg_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        verify_req = 1'b0, prog_req = 1'b0, rbk_en = 1'b0;
  logic        hst_we = 1'b0;
  logic [5:0]  hst_addr = '0, hst_raddr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        busy, done, valid, sum_ok, sig_ok;
  logic        cmd_start;
  logic [1:0]  cmd_op;
  logic [5:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic        cmd_done = 1'b0;
  logic [15:0] cmd_rdata = '0;

  eeimg_seq dut (
    .clk(clk), .rst_n(rst_n), .verify_req(verify_req), .prog_req(prog_req),
    .rbk_en(rbk_en), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_raddr(hst_raddr), .hst_rdata(hst_rdata), .busy(busy), .done(done),
    .valid(valid), .sum_ok(sum_ok), .sig_ok(sig_ok), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // master model state
  logic [15:0] eep [64];
  logic        wren = 1'b0;
  int          lat = 2;
  int          ncmd = 0;
  logic [1:0]  lop  [256];
  logic [5:0]  ladr [256];
  logic [15:0] ldat [256];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
    end
  end

  // EEPROM master model, all activity on falling edges
  initial begin
    logic        pend;
    int          wcnt;
    logic [15:0] rv;
    pend = 1'b0; wcnt = 0; rv = '0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0;
      if (pend) begin
        if (wcnt == 0) begin
          cmd_done  = 1'b1;
          cmd_rdata = rv;
          pend      = 1'b0;
        end else begin
          wcnt--;
        end
      end
      if (rst_n && cmd_start) begin
        if (ncmd < 256) begin
          lop[ncmd] = cmd_op; ladr[ncmd] = cmd_addr; ldat[ncmd] = cmd_wdata;
        end
        ncmd++;
        if (cmd_op == 2'b10) wren = 1'b1;
        if (cmd_op == 2'b01 && wren) eep[cmd_addr] = cmd_wdata;
        rv   = eep[cmd_addr];
        pend = 1'b1;
        wcnt = lat;
      end
    end
  end

  task automatic pulse_verify();
    @(negedge clk); verify_req = 1'b1;
    @(negedge clk); verify_req = 1'b0;
  endtask

  task automatic pulse_prog(input logic rb);
    @(negedge clk); prog_req = 1'b1; rbk_en = rb;
    @(negedge clk); prog_req = 1'b0; rbk_en = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    chk("R4 done timeout", 32'd0, 32'd1);
  endtask

  task automatic host_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); hst_we = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 1'b0;
  endtask

  task automatic host_rd(input logic [5:0] a, output logic [15:0] d);
    hst_raddr = a; #1; d = hst_rdata;
  endtask

  // image: words 0..62 patterned, word 10 carries the signature, word 63 seals
  task automatic make_image(input logic [1:0] sig, input logic [15:0] seal_adj);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 63; i++) begin
      eep[i] = 16'(i * 16'h0321 + 16'h1357);
      if (i == 10) eep[i] = {sig, 14'h2ABC};
      s = s + eep[i];
    end
    eep[63] = 16'hBABA - s + seal_adj;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 valid", valid, 0);
    chk("R1 sum_ok", sum_ok, 0);
    chk("R1 sig_ok", sig_ok, 0);
    chk("R1 cmd_start", cmd_start, 0);
  endtask

  task automatic t_verify(input logic [1:0] sig, input logic [15:0] adj, input int l);
    logic [15:0] s;
    logic [15:0] d;
    logic        bad;
    lat = l;
    make_image(sig, adj);
    s = '0;
    for (int i = 0; i < 64; i++) s = s + eep[i];
    ncmd = 0;
    pulse_verify();
    chk("R11 busy after request", busy, 1);
    wait_done();
    chk("R4 busy low at done", busy, 0);
    chk("R3 sum_ok", sum_ok, (s == 16'hBABA));
    chk("R4 sig_ok", sig_ok, (eep[10][15:14] == 2'b01));
    chk("R4 valid", valid, (s == 16'hBABA) && (eep[10][15:14] == 2'b01));
    chk("R2 read count", ncmd, 64);
    bad = 1'b0;
    for (int i = 0; i < 64; i++)
      if (lop[i] != 2'b00 || ladr[i] != 6'(i)) bad = 1'b1;
    chk("R2 read order", bad, 0);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
    host_rd(6'd10, d); chk("R5 buffer word 10", d, eep[10]);
    host_rd(6'd63, d); chk("R5 buffer word 63", d, eep[63]);
  endtask

  task automatic t_host();
    logic [15:0] d;
    host_wr(6'd33, 16'hA5C3);
    host_rd(6'd33, d);
    chk("R6 idle host write", d, 16'hA5C3);
  endtask

  task automatic load_buf(input logic [1:0] sig, output logic [15:0] exp_seal);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 64; i++) begin
      logic [15:0] w;
      w = 16'(i * 16'h0777 + 16'h0F0F);
      if (i == 10) w = {sig, 14'h1111};
      if (i < 63) s = s + w;
      host_wr(6'(i), w);
    end
    exp_seal = 16'hBABA - s;
  endtask

  task automatic t_program(input logic rb, input logic [1:0] sig);
    logic [15:0] seal, d, w40;
    logic        bad;
    logic        v0;
    lat = 3;
    for (int i = 0; i < 64; i++) eep[i] = 16'hFFFF;
    load_buf(sig, seal);
    host_rd(6'd40, w40);
    v0 = valid;
    ncmd = 0;
    pulse_prog(rb);
    chk("R11 busy after program request", busy, 1);
    // host write while busy must be ignored
    host_wr(6'd40, 16'h0BAD);
    wait_done();
    chk("R7 first op wren", lop[0], 2'b10);
    chk("R7 wren addr", ladr[0], 0);
    bad = 1'b0;
    for (int i = 0; i < 63; i++) begin
      host_rd(6'(i), d);
      if (lop[i+1] != 2'b01 || ladr[i+1] != 6'(i) || ldat[i+1] != d) bad = 1'b1;
    end
    chk("R7 data writes order and data", bad, 0);
    chk("R6 write ignored while busy", eep[40], w40);
    chk("R8 seal addr", ladr[64], 6'd63);
    chk("R8 seal op", lop[64], 2'b01);
    chk("R8 seal data", ldat[64], seal);
    host_rd(6'd63, d);
    chk("R8 buffer seal", d, seal);
    if (!rb) begin
      chk("R10 no readback count", ncmd, 65);
      chk("R10 flags kept", valid, v0);
    end else begin
      chk("R10 readback count", ncmd, 129);
      bad = 1'b0;
      for (int i = 0; i < 64; i++)
        if (lop[65+i] != 2'b00 || ladr[65+i] != 6'(i)) bad = 1'b1;
      chk("R10 readback order", bad, 0);
      chk("R10 readback sum_ok", sum_ok, 1);
      chk("R10 readback sig_ok", sig_ok, (sig == 2'b01));
      chk("R10 readback valid", valid, (sig == 2'b01));
    end
  endtask

  task automatic t_reject_prog();
    make_image(2'b01, 16'h0);
    lat = 1;
    ncmd = 0;
    pulse_verify();
    repeat (3) @(negedge clk);
    prog_req = 1'b1;
    @(negedge clk); prog_req = 1'b0;
    wait_done();
    repeat (6) @(negedge clk);
    chk("R9 prog during verify ignored count", ncmd, 64);
    chk("R9 still idle", busy, 0);
  endtask

  task automatic t_reject_verify();
    logic [15:0] seal;
    logic        anyrd;
    lat = 1;
    load_buf(2'b01, seal);
    ncmd = 0;
    pulse_prog(1'b0);
    repeat (4) @(negedge clk);
    verify_req = 1'b1;
    @(negedge clk); verify_req = 1'b0;
    wait_done();
    repeat (6) @(negedge clk);
    anyrd = 1'b0;
    for (int i = 0; i < 65; i++) if (lop[i] == 2'b00) anyrd = 1'b1;
    chk("R9 verify during program ignored", anyrd, 0);
    chk("R9 program count", ncmd, 65);
  endtask

  task automatic t_both_req();
    make_image(2'b01, 16'h0);
    lat = 0;
    ncmd = 0;
    @(negedge clk); verify_req = 1'b1; prog_req = 1'b1;
    @(negedge clk); verify_req = 1'b0; prog_req = 1'b0;
    wait_done();
    chk("R9 verify wins first op", lop[0], 2'b00);
    chk("R9 verify wins count", ncmd, 64);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) eep[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_verify(2'b01, 16'h0000, 2);   // R3 R4 good image
    t_verify(2'b01, 16'h0001, 1);   // R3 sum off by one
    t_verify(2'b11, 16'h0000, 0);   // R4 bad signature
    t_verify(2'b00, 16'h8000, 4);   // R3 R4 both wrong
    t_host();
    t_program(1'b0, 2'b01);
    t_program(1'b1, 2'b01);
    t_program(1'b1, 2'b10);
    t_reject_prog();
    t_reject_verify();
    t_both_req();
    finish_run();
  end

endmodule